// File: doc/BRIEF.md
# Signal-Strength Conversion Sequencer

This block decides when a single received-signal-strength measurement is taken during a receive session. While receive is enabled it watches a carrier-detect input. It waits until the carrier has been present without a break for longer than a fixed qualification window, 50 µs by default. It then requests one conversion from an external 5-bit ADC, using a one-cycle start pulse and a done strobe.

The converted code and a valid flag are kept in an 8-bit status word that firmware can read. After that one conversion the sequencer halts and ignores the carrier until receive is switched off and back on. Switching receive off clears the valid flag, and the last code stays readable.

Firmware can set a force input that makes an idle channel look occupied. This is how the noise floor of a quiet channel is measured: read the status, set the force bit if the valid flag is clear, wait past the window, read again, then clear the force bit and disable receive.

Top module: `rssi_seq`

## Requirements
- R1: After reset `statusReg` is 0x00 and `adcStart` is low.
- R2: The qualification length is QUAL = floor(CLK_HZ × WINDOW_US / 10^6) + 1 cycles, which is 651 for 13 MHz and 50 µs.
- R3: With receive already enabled, carrier held high starting before rising edge 1 makes `adcStart` high for exactly one cycle, right after rising edge QUAL+1. If receive and carrier rise before the same edge, this happens after edge QUAL+2.
- R4: If the carrier drops for even one cycle before qualification completes, the count restarts, and a full QUAL-cycle wait follows the re-assertion.
- R5: An `adcDone` high at a rising edge while a conversion is pending stores `adcCode` in `statusReg[4:0]` and sets the valid flag `statusReg[5]`. `statusReg[7:6]` read 0. The new value is visible after that edge.
- R6: An `adcDone` at any time no conversion is pending leaves `statusReg` unchanged.
- R7: Once a result is stored, no further `adcStart` occurs while receive stays enabled, whatever the carrier does.
- R8: Receive disabled at a rising edge clears the valid flag at that edge and keeps bits 4:0. Re-enabling receive re-arms qualification.
- R9: Disabling receive during qualification aborts it, and no conversion starts.
- R10: `forceCarrier` high is treated exactly like a detected carrier, with the same QUAL-cycle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive mode on |
| carrierDet | input | 1 | On-channel carrier detected |
| forceCarrier | input | 1 | Firmware override: treat carrier as present |
| adcDone | input | 1 | ADC conversion finished, code valid |
| adcCode | input | 5 | ADC conversion result |
| adcStart | output | 1 | One-cycle conversion request |
| statusReg | output | 8 | {2'b00, valid, code[4:0]} |

## Verification
The main function is driven with four carrier patterns. The first is a carrier that rises after receive is already on, which pins the exact start latency. The second is a carrier that rises together with receive, which adds one cycle for arming. The third is a carrier with a one-cycle gap before qualification, which separates a restarting counter from one that pauses or keeps running. The fourth uses the force input alone, with the carrier idle. Stray done strobes, both before a conversion is pending and after the halt, show that the capture is gated by state. A long carrier after the halt shows that the sequencer does not re-trigger. A receive toggle in the middle of qualification and after a result separates aborting and re-arming from clearing the stored code.

// File: rtl/rssi_seq_pkg.sv
package rssi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_START = 3'd2,
    ST_WAIT  = 3'd3,
    ST_HALT  = 3'd4
  } seqState_e;

  typedef struct packed {
    logic countEn;
    logic capture;
    logic clearValid;
  } seqStrobes_t;

  // Cycles strictly longer than the window: floor(clk * window) + 1
  function automatic int qualCycles(input int clkHz, input int winUs);
    return ((clkHz / 1000) * winUs) / 1000 + 1;
  endfunction

endpackage

// File: rtl/rssi_seq_ctrl.sv
module rssi_seq_ctrl
  import rssi_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEnable,
  input  logic        qualified,
  input  logic        adcDone,
  output logic        adcStart,
  output seqStrobes_t strobes
);

  seqState_e state, stateNext;

  always_comb begin
    stateNext          = state;
    strobes            = '0;
    strobes.clearValid = !rxEnable;
    if (!rxEnable) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  stateNext = ST_ARMED;
        ST_ARMED: begin
          strobes.countEn = 1'b1;
          if (qualified) stateNext = ST_START;
        end
        ST_START: stateNext = ST_WAIT;
        ST_WAIT: begin
          if (adcDone) begin
            strobes.capture = 1'b1;
            stateNext       = ST_HALT;
          end
        end
        ST_HALT:  stateNext = ST_HALT;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign adcStart = (state == ST_START);

  // R3
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R4
  start_after_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> $past(qualified));

endmodule

// File: rtl/rssi_seq_datapath.sv
module rssi_seq_datapath
  import rssi_seq_pkg::*;
#(
  parameter int QUAL_CYCLES = 651,
  parameter int CODE_W      = 5,
  parameter int STATUS_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                carrierDet,
  input  logic                forceCarrier,
  input  logic [CODE_W-1:0]   adcCode,
  input  seqStrobes_t         strobes,
  output logic                qualified,
  output logic [STATUS_W-1:0] statusReg
);

  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

  logic              carrierEff;
  logic [CNT_W-1:0]  qualCount;
  logic [CODE_W-1:0] result;
  logic              valid;

  assign carrierEff = carrierDet | forceCarrier;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qualCount <= '0;
    end else if (strobes.countEn && carrierEff) begin
      if (qualCount != CNT_MAX) qualCount <= qualCount + 1'b1;
    end else begin
      qualCount <= '0;
    end
  end

  assign qualified = (qualCount == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      valid  <= 1'b0;
    end else if (strobes.clearValid) begin
      valid  <= 1'b0;
    end else if (strobes.capture) begin
      result <= adcCode;
      valid  <= 1'b1;
    end
  end

  assign statusReg = {{(STATUS_W - CODE_W - 1){1'b0}}, valid, result};

  // R5
  capture_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (statusReg[CODE_W] && statusReg[CODE_W-1:0] == $past(adcCode)));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    qualCount <= CNT_MAX);

endmodule

// File: rtl/rssi_seq.sv
module rssi_seq
  import rssi_seq_pkg::*;
#(
  parameter int CLK_HZ    = 13_000_000,
  parameter int WINDOW_US = 50,
  parameter int CODE_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              carrierDet,
  input  logic              forceCarrier,
  input  logic              adcDone,
  input  logic [CODE_W-1:0] adcCode,
  output logic              adcStart,
  output logic [7:0]        statusReg
);

  localparam int QUAL_CYCLES = qualCycles(CLK_HZ, WINDOW_US);

  seqStrobes_t strobes;
  logic        qualified;

  rssi_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxEnable (rxEnable),
    .qualified(qualified),
    .adcDone  (adcDone),
    .adcStart (adcStart),
    .strobes  (strobes)
  );

  rssi_seq_datapath #(
    .QUAL_CYCLES(QUAL_CYCLES),
    .CODE_W     (CODE_W),
    .STATUS_W   (8)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .carrierDet  (carrierDet),
    .forceCarrier(forceCarrier),
    .adcCode     (adcCode),
    .strobes     (strobes),
    .qualified   (qualified),
    .statusReg   (statusReg)
  );

  // R8
  rx_off_clears_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !statusReg[CODE_W]);

  // R7
  halt_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[CODE_W] && rxEnable) |=> (statusReg[CODE_W] && !adcStart));

endmodule

// File: tb/rssi_seq_tb_top.sv
module rssi_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  // 13 MHz * 50 us = 650 cycles; strictly longer means 651 (R2)
  localparam int EXP_QUAL = 651;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0;
  logic       carrierDet = 1'b0;
  logic       forceCarrier = 1'b0;
  logic       adcDone = 1'b0;
  logic [4:0] adcCode = '0;
  logic       adcStart;
  logic [7:0] statusReg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rssi_seq dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .carrierDet(carrierDet),
    .forceCarrier(forceCarrier), .adcDone(adcDone), .adcCode(adcCode),
    .adcStart(adcStart), .statusReg(statusReg)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pops the expected status when a pending done is consumed (R5)
  always @(posedge clk) begin
    #1;
    if (adcDone && expQ.size() > 0) begin
      check("R5 stored status", statusReg, expQ.pop_front());
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  task automatic waitStart(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      n++;
      if (adcStart) return;
    end
    n = -1;
  endtask

  task automatic countStarts(input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (adcStart) n++;
    end
  endtask

  // Driver: plays the ADC, pushes the expected status word
  task automatic adcRespond(input logic [4:0] code);
    expQ.push_back({2'b00, 1'b1, code});
    repeat (3) @(negedge clk);
    adcCode = code;
    adcDone = 1'b1;
    @(negedge clk);
    adcDone = 1'b0;
    adcCode = '0;
  endtask

  task automatic strayDone(input logic [4:0] code);
    adcCode = code;
    adcDone = 1'b1;
    @(negedge clk);
    adcDone = 1'b0;
    adcCode = '0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset status", statusReg, 8'h00);
    check("R1 reset start", adcStart, 0);

    // R6: stray done while armed, nothing pending
    rxEnable = 1'b1;
    repeat (5) @(negedge clk);
    strayDone(5'h1F);
    check("R6 stray done before conversion", statusReg, 8'h00);

    // R4: gap before threshold restarts the count
    carrierDet = 1'b1;
    countStarts(400, n);
    check("R4 no start before gap", n, 0);
    carrierDet = 1'b0;
    @(negedge clk);
    carrierDet = 1'b1;
    waitStart(2000, n);
    // R3 R2: start right after edge QUAL+1
    check("R4 R3 latency after regap", n, EXP_QUAL + 1);
    @(negedge clk);
    check("R3 start one cycle", adcStart, 0);
    adcRespond(5'h0A);
    @(negedge clk);
    check("R5 status after capture", statusReg, 8'h2A);

    // R7: halted with carrier still present
    countStarts(800, n);
    check("R7 no restart while halted", n, 0);
    strayDone(5'h03);
    check("R6 stray done after halt", statusReg, 8'h2A);

    // R8: rx off clears valid only
    rxEnable = 1'b0;
    @(negedge clk);
    check("R8 valid cleared code kept", statusReg, 8'h0A);

    // R8 R3: rx and carrier together
    rxEnable = 1'b1;
    waitStart(2000, n);
    check("R8 R3 latency from rx on", n, EXP_QUAL + 2);
    adcRespond(5'h13);
    @(negedge clk);
    check("R5 second capture", statusReg, 8'h33);

    // R9: abort during qualification
    rxEnable = 1'b0;
    carrierDet = 1'b0;
    @(negedge clk);
    rxEnable = 1'b1;
    carrierDet = 1'b1;
    countStarts(300, n);
    rxEnable = 1'b0;
    carrierDet = 1'b0;
    begin
      int m;
      countStarts(700, m);
      check("R9 no start after abort", n + m, 0);
    end
    check("R9 status after abort", statusReg, 8'h13);

    // R10: forced idle channel
    rxEnable = 1'b1;
    repeat (3) @(negedge clk);
    forceCarrier = 1'b1;
    waitStart(2000, n);
    check("R10 forced latency", n, EXP_QUAL + 1);
    adcRespond(5'h07);
    @(negedge clk);
    check("R10 forced result", statusReg, 8'h27);
    forceCarrier = 1'b0;
    rxEnable = 1'b0;
    @(negedge clk);
    check("R8 final rx off", statusReg, 8'h07);
    check("R5 all expected consumed", expQ.size(), 0);

    finishRun();
  end

endmodule